// File: doc/BRIEF.md
# Four-Bit Arithmetic Logic Unit with Carry and Zero Flags

This block is a purely combinational arithmetic logic unit. It has a parameterised word width, and the default is 4 bits. It takes two operand words and a 3-bit operation code. It returns a result word and two flags: a carry flag and a zero flag. The block holds no state and has no clock. Every output follows its inputs within the same evaluation.

Addition and subtraction share one ripple-carry adder. The adder is a chain of full adders, and each full adder is built from two half adders. For subtraction, a mode bit flips every bit of the second operand through XOR gates. The same mode bit also drives the adder's carry-in, so the adder computes A plus the inverted B plus one. The unit also offers bitwise AND, OR and XOR, and single-place logical shifts of operand A in either direction. The carry flag catches whichever bit falls off the end of the word.

Top module: `tiny_alu`

## Requirements
- R1: Code 000 (add) gives the low WIDTH bits of A + B on `result`, and `carry_out` holds the carry out of the most significant bit. For example, 1001 + 0111 gives 0000 with carry 1.
- R2: Code 001 (subtract) gives (A − B) modulo 2^WIDTH, formed as A + ~B + 1. `carry_out` is the raw adder carry, so it is 1 exactly when A ≥ B taken as unsigned numbers. For example, 0110 − 0001 gives 0101 with carry 1.
- R3: Codes 010 (AND), 011 (OR) and 100 (XOR) combine each bit of A with the bit of B at the same position and return a full-width word. `carry_out` is 0 for these codes.
- R4: Code 101 shifts A left by one place and puts 0 in bit 0. `carry_out` takes the old most significant bit of A. B has no effect.
- R5: Code 110 shifts A right by one place and puts 0 in the most significant bit. `carry_out` takes the old bit 0 of A. B has no effect.
- R6: Code 111 returns an all-zero `result` with `carry_out` at 0, whatever A and B are.
- R7: `zero_out` is 1 exactly when `result` is all zeros, for every operation code.
- R8: The block has no clock or state. When an input changes between clock edges, the outputs settle to the new values without waiting for any edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | WIDTH | First operand; the only operand for the shifts |
| opnd_b | input | WIDTH | Second operand |
| op_sel | input | 3 | Operation code (see R1 to R6) |
| result | output | WIDTH | Result word |
| carry_out | output | 1 | Carry, no-borrow, or shifted-out bit |
| zero_out | output | 1 | High when the result word is all zeros |

## Verification
The bench builds the unit with WIDTH at its default of 4. At that width, every combination of both operands and all eight operation codes fits in 2048 steps. The bench therefore sweeps the whole input space and checks it against an integer model of its own. The sweep covers every wrap of the carry, every borrow, every bit that shifts out, and every way of reaching a zero result. It also covers every unused-code input. Ahead of the sweep, a short table of hand-worked cases checks the worked examples, and a directed mid-cycle change shows that the outputs respond without a clock.

// File: rtl/tiny_alu_pkg.sv
package tiny_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'b000,
    OP_SUB  = 3'b001,
    OP_AND  = 3'b010,
    OP_OR   = 3'b011,
    OP_XOR  = 3'b100,
    OP_SHL  = 3'b101,
    OP_SHR  = 3'b110,
    OP_NONE = 3'b111
  } alu_op_e;

  // single-bit arithmetic kept in functions so the cell structure is explicit
  function automatic logic bit_sum(input logic x, input logic y);
    return x ^ y;
  endfunction

  function automatic logic bit_carry(input logic x, input logic y);
    return x & y;
  endfunction

endpackage

// File: rtl/alu_half_add.sv
module alu_half_add
  import tiny_alu_pkg::*;
(
  input  logic x,
  input  logic y,
  output logic s,
  output logic c
);
  assign s = bit_sum(x, y);
  assign c = bit_carry(x, y);
endmodule

// File: rtl/alu_full_add.sv
module alu_full_add (
  input  logic x,
  input  logic y,
  input  logic cin,
  output logic s,
  output logic cout
);
  logic s_mid;
  logic c_first;
  logic c_second;

  alu_half_add u_ha0 (.x(x),     .y(y),   .s(s_mid), .c(c_first));
  alu_half_add u_ha1 (.x(s_mid), .y(cin), .s(s),     .c(c_second));

  assign cout = c_first | c_second;
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sub_mode,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  logic [WIDTH-1:0] b_cond;
  logic [WIDTH:0]   chain;

  assign chain[0] = sub_mode;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    assign b_cond[i] = b[i] ^ sub_mode;
    alu_full_add u_fa (
      .x   (a[i]),
      .y   (b_cond[i]),
      .cin (chain[i]),
      .s   (sum[i]),
      .cout(chain[i+1])
    );
  end

  assign cout = chain[WIDTH];
endmodule

// File: rtl/alu_shift1.sv
module alu_shift1 #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic             go_right,
  output logic [WIDTH-1:0] y,
  output logic             spill
);
  always_comb begin
    if (go_right) begin
      y     = {1'b0, a[WIDTH-1:1]};
      spill = a[0];
    end else begin
      y     = {a[WIDTH-2:0], 1'b0};
      spill = a[WIDTH-1];
    end
  end
endmodule

// File: rtl/tiny_alu.sv
module tiny_alu
  import tiny_alu_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [2:0]       op_sel,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             zero_out
);
  localparam logic [WIDTH-1:0] ALL_ZERO = '0;

  alu_op_e          op;
  logic             sub_mode;
  logic [WIDTH-1:0] as_word;
  logic             as_carry;
  logic [WIDTH-1:0] sh_word;
  logic             sh_spill;

  assign op       = alu_op_e'(op_sel);
  assign sub_mode = (op == OP_SUB);

  alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a       (opnd_a),
    .b       (opnd_b),
    .sub_mode(sub_mode),
    .sum     (as_word),
    .cout    (as_carry)
  );

  alu_shift1 #(.WIDTH(WIDTH)) u_shift (
    .a       (opnd_a),
    .go_right(op == OP_SHR),
    .y       (sh_word),
    .spill   (sh_spill)
  );

  always_comb begin
    result    = ALL_ZERO;
    carry_out = 1'b0;
    unique case (op)
      OP_ADD, OP_SUB: begin result = as_word; carry_out = as_carry; end
      OP_AND:         result = opnd_a & opnd_b;
      OP_OR:          result = opnd_a | opnd_b;
      OP_XOR:         result = opnd_a ^ opnd_b;
      OP_SHL, OP_SHR: begin result = sh_word; carry_out = sh_spill; end
      default:        ;
    endcase
  end

  assign zero_out = (result == ALL_ZERO);

  // checks against plain operators, independent of the ripple structure
  always_comb begin
    if (op == OP_ADD)
      assert_add_sum_R1: assert ({carry_out, result} == ({1'b0, opnd_a} + {1'b0, opnd_b}));
    if (op == OP_SUB) begin
      assert_sub_diff_R2: assert (result == WIDTH'(opnd_a - opnd_b));
      assert_sub_noborrow_R2: assert (carry_out == (opnd_a >= opnd_b));
    end
    if (op == OP_AND || op == OP_OR || op == OP_XOR)
      assert_logic_nocarry_R3: assert (!carry_out);
    if (op == OP_SHL)
      assert_shl_fill_R4: assert (!result[0] && carry_out == opnd_a[WIDTH-1]);
    if (op == OP_SHR)
      assert_shr_fill_R5: assert (!result[WIDTH-1] && carry_out == opnd_a[0]);
    if (op == OP_NONE)
      assert_idle_clear_R6: assert (zero_out && !carry_out);
  end
endmodule

// File: tb/sim_tiny_alu.sv
module sim_tiny_alu;
  localparam int W = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic [2:0]   op = 3'b000;
  logic [W-1:0] res;
  logic         cy;
  logic         zf;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  tiny_alu #(.WIDTH(W)) u0 (
    .opnd_a   (a),
    .opnd_b   (b),
    .op_sel   (op),
    .result   (res),
    .carry_out(cy),
    .zero_out (zf)
  );

  // fields: [15:13] op, [12:9] a, [8:5] b, [4] carry, [3:0] result
  localparam logic [15:0] VEC [13] = '{
    {3'b000, 4'b1010, 4'b0101, 1'b0, 4'b1111},
    {3'b000, 4'b1001, 4'b0111, 1'b1, 4'b0000},
    {3'b001, 4'b0110, 4'b0001, 1'b1, 4'b0101},
    {3'b001, 4'b0001, 4'b0110, 1'b0, 4'b1011},
    {3'b001, 4'b0101, 4'b0101, 1'b1, 4'b0000},
    {3'b010, 4'b1100, 4'b1010, 1'b0, 4'b1000},
    {3'b011, 4'b1100, 4'b1010, 1'b0, 4'b1110},
    {3'b100, 4'b1100, 4'b1010, 1'b0, 4'b0110},
    {3'b101, 4'b0101, 4'b1111, 1'b0, 4'b1010},
    {3'b101, 4'b1011, 4'b0000, 1'b1, 4'b0110},
    {3'b110, 4'b1010, 4'b1111, 1'b0, 4'b0101},
    {3'b110, 4'b0111, 4'b0000, 1'b1, 4'b0011},
    {3'b111, 4'b1111, 4'b1111, 1'b0, 4'b0000}
  };

  function automatic string tag_of(input int o);
    case (o)
      0: return "R1";
      1: return "R2";
      2, 3, 4: return "R3";
      5: return "R4";
      6: return "R5";
      default: return "R6";
    endcase
  endfunction

  // integer reference: returns {carry, result}
  function automatic logic [W:0] model(input int o, input int x, input int y);
    int mask;
    int r;
    int c;
    mask = (1 << W) - 1;
    r = 0;
    c = 0;
    case (o)
      0: begin r = (x + y) & mask; c = ((x + y) >> W) & 1; end
      1: begin r = (x - y) & mask; c = (x >= y) ? 1 : 0; end
      2: r = x & y;
      3: r = x | y;
      4: r = x ^ y;
      5: begin r = (x * 2) & mask; c = (x >> (W - 1)) & 1; end
      6: begin r = x / 2; c = x % 2; end
      default: ;
    endcase
    return {c[0], r[W-1:0]};
  endfunction

  task automatic apply(input logic [2:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
    @(negedge clk);
    op = o;
    a  = x;
    b  = y;
    #1;
  endtask

  task automatic compare(input string tag, input logic [W-1:0] er, input logic ec);
    n_cmp++;
    if (res !== er || cy !== ec) begin
      n_bad++;
      $display("FAIL %s op=%0d a=%b b=%b: got r=%b c=%b, expected r=%b c=%b",
               tag, op, a, b, res, cy, er, ec);
    end
    n_cmp++;
    if (zf !== (er == '0)) begin
      n_bad++;
      $display("FAIL R7 op=%0d a=%b b=%b: got z=%b, expected z=%b",
               op, a, b, zf, (er == '0));
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    logic [W:0] exp_v;
    // state at start: ADD of zeros, R1 and R7
    #1;
    compare("R1", 4'b0000, 1'b0);

    foreach (VEC[i]) begin
      apply(VEC[i][15:13], VEC[i][12:9], VEC[i][8:5]);
      compare(tag_of(int'(VEC[i][15:13])), VEC[i][3:0], VEC[i][4]);
    end

    // R8: change inputs mid-cycle, away from any edge
    apply(3'b000, 4'b0011, 4'b0100);
    #4;
    a = 4'b1000;
    b = 4'b1000;
    #1;
    compare("R8", 4'b0000, 1'b1);

    // exhaustive sweep against the integer model
    for (int o = 0; o < 8; o++) begin
      for (int x = 0; x < (1 << W); x++) begin
        for (int y = 0; y < (1 << W); y++) begin
          apply(o[2:0], x[W-1:0], y[W-1:0]);
          exp_v = model(o, x, y);
          compare(tag_of(o), exp_v[W-1:0], exp_v[W]);
        end
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R8 watchdog: got run still active, expected completion");
      summary();
      $finish;
    end
  end
endmodule